// File: doc/BRIEF.md
# Two-Page SPI Register File Slave

This block lets an SPI host reach a byte-wide register file that is split into pages. Each page holds 128 locations, so a 7-bit address selects a location. Location 0 is never paged: it is the page-select register, and it looks the same from every page. Locations 1 to 127 belong to whichever page is active. The core logic on the chip gets its own simple port to read and write any location of any page.

A host transaction is one chip-select-low frame. It starts with a command byte that carries the address and the direction, followed by any number of data bytes. Each data byte moves the address on by one. A burst stops at location 127. It never wraps and never spills into another page. Raising chip select ends the frame at once, and the next frame must start again with a command byte.

The SPI pins are oversampled by the system clock. The frame logic is a five-state machine with these states:
- ST_IDLE: chip select high.
- ST_CMD: the command byte is being shifted in.
- ST_WRITE: data bytes are being stored.
- ST_READ: data bytes are being shifted out.
- ST_PAST_END: the burst has run beyond location 127.

The machine takes these transitions:
- A chip-select fall enters ST_CMD from any state.
- A chip-select rise returns to ST_IDLE from any state.
- At the end of the command byte, ST_CMD goes to ST_READ or ST_WRITE, chosen by the direction bit.
- ST_READ and ST_WRITE go to ST_PAST_END when a byte completes at location 127.
- ST_PAST_END is left only through chip select.

Top module: `paged_spi_regfile`

## Requirements
- R1: After reset, page 0 is active, every location of every page reads 0x00 and MISO is low.
- R2: The command byte is sent MSB first. Bits [7:1] are the start address and bit 0 is the direction (1 = read, 0 = write). MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge (SPI mode 0).
- R3: A written data byte is stored only once all 8 of its bits have arrived. A partial byte that is cut off by chip select rising changes nothing.
- R4: In a write frame, successive data bytes go to the start address and then to each following address in turn.
- R5: In a read frame, the byte at the start address appears on MISO, MSB first, from the edge that completes the command byte. The following bytes come from the following addresses, each fetched at the boundary of the previous byte.
- R6: Location 0 is the page select on every page. A write stores bit 0 of the data as the active page and ignores bits [7:1]. A read returns the active page in bit 0, with bits [7:1] zero. A write at location 0 inside a burst changes the page used by the very next byte.
- R7: Locations 1 to 127 reach only the active page. An SPI write never changes the same location on the other page.
- R8: Once a burst has handled location 127, further written bytes are discarded and further read bytes are 0x00 until chip select rises. Nothing wraps.
- R9: A rising chip select ends the frame. The first byte of the next frame is always taken as a new command byte.
- R10: The host port reads `host_rdata` combinationally from page `host_page`, location `host_addr`. A pulse of `host_we` writes `host_wdata` there on the next clock edge. At location 0 the port reads the active page, and a write there is ignored.
- R11: MISO stays low outside the data bytes of a read frame: during the command byte, during write frames and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low; frames the transaction |
| spi_sclk | input | 1 | Serial clock from the host, mode 0 |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| host_page | input | PAGE_W (1) | Page addressed by the host port |
| host_addr | input | 7 | Location addressed by the host port |
| host_we | input | 1 | Host port write strobe |
| host_wdata | input | 8 | Host port write data |
| host_rdata | output | 8 | Host port read data |

## Verification
The bench builds the block with its default parameters: two pages, 8-bit data (and therefore 7-bit addresses) and a two-stage pin synchronizer. Because the address space is small, a burst that starts at location 125 or 126 reaches the end of the page in a few bytes. That makes the discard-and-zero behaviour and the absence of wrap cheap to observe. With exactly two pages, every page switch gives a visible contrast, so a wrong page mapping shows up on the untouched page through the host port.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;

    // Frame-level state of the serial interface.
    typedef enum logic [2:0] {
        ST_IDLE,      // chip select high
        ST_CMD,       // collecting the command byte
        ST_WRITE,     // storing data bytes
        ST_READ,      // returning data bytes
        ST_PAST_END   // burst ran beyond the last location of the page
    } frame_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              cs_d;
    logic              sclk_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_pipe   <= '1;
                    sclk_pipe <= '0;
                    mosi_pipe <= '0;
                end else begin
                    cs_pipe   <= cs_n;
                    sclk_pipe <= sclk;
                    mosi_pipe <= mosi;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_pipe   <= '1;
                    sclk_pipe <= '0;
                    mosi_pipe <= '0;
                end else begin
                    cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
                    sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
                    mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_pipe[TOP];
            sclk_d <= sclk_pipe[TOP];
        end
    end

    always_comb begin
        sclk_rise = sclk_pipe[TOP] & ~sclk_d;
        sclk_fall = ~sclk_pipe[TOP] & sclk_d;
        cs_fall   = ~cs_pipe[TOP] & cs_d;
        cs_rise   = cs_pipe[TOP] & ~cs_d;
        mosi_s    = mosi_pipe[TOP];
    end

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regfile_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output frame_state_t      state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              byte_end_o
);

    localparam int                CNT_W     = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  BIT_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    frame_state_t      state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rx_next;
    logic              byte_end;
    logic              in_frame;

    always_comb begin
        rx_next  = {rx_q[DATA_W-2:0], mosi_s};
        in_frame = (state_q != ST_IDLE);
        byte_end = sclk_rise && !cs_fall && !cs_rise && in_frame && (bit_cnt_q == BIT_LAST);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (cs_fall) begin
            state_d = ST_CMD;
        end else if (cs_rise) begin
            state_d = ST_IDLE;
        end else if (byte_end) begin
            unique case (state_q)
                ST_CMD:      state_d = rx_next[0] ? ST_READ : ST_WRITE;
                ST_WRITE:    state_d = (addr_q == ADDR_LAST) ? ST_PAST_END : ST_WRITE;
                ST_READ:     state_d = (addr_q == ADDR_LAST) ? ST_PAST_END : ST_READ;
                ST_PAST_END: state_d = ST_PAST_END;
                ST_IDLE:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift registers, bit counter and burst address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            addr_q    <= '0;
        end else if (cs_fall || cs_rise) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
        end else if (sclk_rise && in_frame) begin
            rx_q      <= rx_next;
            bit_cnt_q <= (bit_cnt_q == BIT_LAST) ? '0 : bit_cnt_q + 1'b1;
            if (byte_end) begin
                unique case (state_q)
                    ST_CMD: begin
                        addr_q <= rx_next[DATA_W-1:1];
                        tx_q   <= rx_next[0] ? rd_data : '0;
                    end
                    ST_WRITE: begin
                        if (addr_q != ADDR_LAST) addr_q <= addr_q + 1'b1;
                    end
                    ST_READ: begin
                        if (addr_q != ADDR_LAST) begin
                            addr_q <= addr_q + 1'b1;
                            tx_q   <= rd_data;
                        end else begin
                            tx_q   <= '0;
                        end
                    end
                    ST_PAST_END: tx_q <= '0;
                    ST_IDLE:     tx_q <= '0;
                endcase
            end
        end else if (sclk_fall && (state_q == ST_READ) && (bit_cnt_q != '0)) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Outputs.
    always_comb begin
        rd_addr    = (state_q == ST_CMD) ? rx_next[DATA_W-1:1] : addr_q + 1'b1;
        wr_en      = byte_end && (state_q == ST_WRITE);
        wr_addr    = addr_q;
        wr_data    = rx_next;
        miso       = tx_q[DATA_W-1];
        state_o    = state_q;
        addr_o     = addr_q;
        byte_end_o = byte_end;
    end

endmodule

// File: rtl/paged_reg_bank.sv
module paged_reg_bank #(
    parameter int NUM_PAGES = 2,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = DATA_W - 1,
    parameter int PAGE_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spi_rd_addr,
    output logic [DATA_W-1:0] spi_rd_data,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_waddr,
    input  logic [DATA_W-1:0] spi_wdata,
    input  logic [PAGE_W-1:0] ip_page,
    input  logic [ADDR_W-1:0] ip_addr,
    input  logic              ip_we,
    input  logic [DATA_W-1:0] ip_wdata,
    output logic [DATA_W-1:0] ip_rdata,
    output logic [PAGE_W-1:0] page_o
);

    localparam int REGS = 1 << ADDR_W;

    logic [PAGE_W-1:0]                   page_q;
    logic [NUM_PAGES-1:0][DATA_W-1:0]    spi_pg_rd;
    logic [NUM_PAGES-1:0][DATA_W-1:0]    ip_pg_rd;

    // Page select lives at location 0 and is shared by all pages.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               page_q <= '0;
        else if (spi_we && (spi_waddr == '0))     page_q <= spi_wdata[PAGE_W-1:0];
    end

    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
            logic [DATA_W-1:0] regs_q [REGS];
            logic              spi_hit;
            logic              ip_hit;

            always_comb begin
                spi_hit = spi_we && (spi_waddr != '0) && (page_q == PAGE_W'(p));
                ip_hit  = ip_we && (ip_addr != '0) && (ip_page == PAGE_W'(p));
            end

            // The serial side wins when both sides write in one cycle.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int r = 0; r < REGS; r++) regs_q[r] <= '0;
                end else if (spi_hit) begin
                    regs_q[spi_waddr] <= spi_wdata;
                end else if (ip_hit) begin
                    regs_q[ip_addr] <= ip_wdata;
                end
            end

            assign spi_pg_rd[p] = regs_q[spi_rd_addr];
            assign ip_pg_rd[p]  = regs_q[ip_addr];
        end
    endgenerate

    always_comb begin
        spi_rd_data = (spi_rd_addr == '0) ? DATA_W'(page_q) : spi_pg_rd[page_q];
        ip_rdata    = (ip_addr == '0)     ? DATA_W'(page_q) : ip_pg_rd[ip_page];
        page_o      = page_q;
    end

endmodule

// File: rtl/paged_spi_regfile.sv
module paged_spi_regfile
    import spi_regfile_pkg::*;
#(
    parameter int NUM_PAGES   = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = DATA_W - 1,
    parameter int PAGE_W      = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [PAGE_W-1:0] host_page,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_fall_evt;
    logic              cs_rise_evt;
    logic              mosi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_waddr;
    logic [DATA_W-1:0] reg_wdata;
    frame_state_t      fsm_state;
    logic [ADDR_W-1:0] fsm_addr;
    logic              byte_end;
    logic [PAGE_W-1:0] page_q;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall_evt),
        .cs_rise   (cs_rise_evt),
        .mosi_s    (mosi_s)
    );

    spi_frame_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .cs_fall    (cs_fall_evt),
        .cs_rise    (cs_rise_evt),
        .mosi_s     (mosi_s),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (reg_we),
        .wr_addr    (reg_waddr),
        .wr_data    (reg_wdata),
        .miso       (spi_miso),
        .state_o    (fsm_state),
        .addr_o     (fsm_addr),
        .byte_end_o (byte_end)
    );

    paged_reg_bank #(
        .NUM_PAGES (NUM_PAGES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_rd_addr (rd_addr),
        .spi_rd_data (rd_data),
        .spi_we      (reg_we),
        .spi_waddr   (reg_waddr),
        .spi_wdata   (reg_wdata),
        .ip_page     (host_page),
        .ip_addr     (host_addr),
        .ip_we       (host_we),
        .ip_wdata    (host_wdata),
        .ip_rdata    (host_rdata),
        .page_o      (page_q)
    );

endmodule

// File: rtl/spi_regfile_checker.sv
module spi_regfile_checker
    import spi_regfile_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - 1,
    parameter int PAGE_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input frame_state_t      state,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [PAGE_W-1:0] page,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              byte_end,
    input logic              cs_rise,
    input logic              miso
);

    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    AST_PAGE_ONLY_BY_LOC0: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page) |-> $past(wr_en && (wr_addr == '0)));  // R6

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READ) |-> !miso);  // R11

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && (state inside {ST_WRITE, ST_READ}) && (cur_addr != ADDR_LAST))
        |=> (cur_addr == $past(cur_addr) + 1'b1));  // R4

    AST_CS_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_IDLE));  // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAST_END) |=> (state inside {ST_PAST_END, ST_IDLE, ST_CMD}));  // R8

endmodule

bind paged_spi_regfile spi_regfile_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .cur_addr (fsm_addr),
    .page     (page_q),
    .wr_en    (reg_we),
    .wr_addr  (reg_waddr),
    .byte_end (byte_end),
    .cs_rise  (cs_rise_evt),
    .miso     (spi_miso)
);

// File: tb/paged_spi_regfile_tb.sv
module paged_spi_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;   // system clocks per SCLK half period
    localparam int SETTLE     = 6;   // clocks before MISO is compared again

    logic       clk;
    logic       rst_n;
    logic       spi_cs_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso;
    logic [0:0] host_page;
    logic [6:0] host_addr;
    logic       host_we;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;

    paged_spi_regfile u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .host_page  (host_page),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    bit    mon_en = 0;
    logic  exp_miso = 1'b0;
    string mon_req = "R1";

    // Reference model.
    logic [7:0] mdl [2][128];
    int         mdl_page = 0;
    logic [7:0] rdq[$];

    function automatic logic [7:0] mdl_rd(int pg, int a);
        return (a == 0) ? 8'(mdl_page) : mdl[pg][a];
    endfunction

    task automatic mdl_spi_wr(int a, logic [7:0] d);
        if (a == 0) mdl_page = int'(d[0]);
        else        mdl[mdl_page][a] = d;
    endtask

    // MISO compared on every clock while enabled.
    always @(negedge clk) begin
        if (mon_en && !done) begin
            n_cmp++;
            if (spi_miso !== exp_miso) begin
                n_bad++;
                $display("FAIL %s miso actual=%b expected=%b at %0t", mon_req, spi_miso, exp_miso, $time);
            end
        end
    end

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_change(logic sclk_v, logic cs_v, logic nxt_exp);
        mon_en   = 0;
        spi_sclk = sclk_v;
        spi_cs_n = cs_v;
        wait_clk(SETTLE);
        exp_miso = nxt_exp;
        mon_en   = 1;
        wait_clk(HALF_BIT - SETTLE);
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] cur, input logic [7:0] nxt,
                        input string req, output logic [7:0] got);
        mon_req = req;
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF_BIT);
            got[i] = spi_miso;
            pin_change(1'b1, 1'b0, (i == 0) ? nxt[7] : cur[i]);
            pin_change(1'b0, 1'b0, (i == 0) ? nxt[7] : cur[i-1]);
        end
    endtask

    task automatic frame_open();
        mon_req = "R11";
        pin_change(1'b0, 1'b0, 1'b0);
    endtask

    task automatic frame_close();
        mon_req = "R11";
        wait_clk(HALF_BIT);
        pin_change(1'b0, 1'b1, 1'b0);
        wait_clk(2 * HALF_BIT);
    endtask

    // One complete frame; read bytes land in rdq.
    task automatic run_frame(input int a, input bit rd, input logic [7:0] wq[$], input int n);
        logic [7:0] expq[$];
        logic [7:0] got;
        int  pa;
        bit  past;
        rdq.delete();
        pa = a;
        past = 0;
        if (rd) begin
            for (int k = 0; k <= n; k++) begin
                expq.push_back(past ? 8'h00 : mdl_rd(mdl_page, pa));
                if (!past) begin
                    if (pa == 127) past = 1;
                    else pa++;
                end
            end
        end
        frame_open();
        xfer({7'(a), rd}, 8'h00, rd ? expq[0] : 8'h00, "R11", got);
        pa = a;
        past = 0;
        for (int k = 0; k < n; k++) begin
            if (rd) begin
                xfer(8'h00, expq[k], expq[k+1], "R5", got);
                chk8("R5 read byte", got, expq[k]);
                rdq.push_back(got);
            end else begin
                xfer(wq[k], 8'h00, 8'h00, "R11", got);
                if (!past) begin
                    mdl_spi_wr(pa, wq[k]);
                    if (pa == 127) past = 1;
                    else pa++;
                end
            end
        end
        frame_close();
    endtask

    // Command plus a data byte cut off after a few bits.
    task automatic partial_frame(input int a, input logic [7:0] d, input int bits);
        logic [7:0] got;
        frame_open();
        xfer({7'(a), 1'b0}, 8'h00, 8'h00, "R11", got);
        mon_req = "R3";
        for (int i = 7; i > 7 - bits; i--) begin
            spi_mosi = d[i];
            wait_clk(HALF_BIT);
            pin_change(1'b1, 1'b0, 1'b0);
            pin_change(1'b0, 1'b0, 1'b0);
        end
        frame_close();
    endtask

    task automatic host_read(input int pg, input int a, output logic [7:0] v);
        host_page = 1'(pg);
        host_addr = 7'(a);
        wait_clk(1);
        v = host_rdata;
    endtask

    task automatic host_write(input int pg, input int a, input logic [7:0] d);
        host_page  = 1'(pg);
        host_addr  = 7'(a);
        host_wdata = d;
        host_we    = 1'b1;
        wait_clk(1);
        host_we    = 1'b0;
        if (a != 0) mdl[pg][a] = d;
        wait_clk(1);
    endtask

    task automatic host_check_all(string req);
        logic [7:0] v;
        for (int pg = 0; pg < 2; pg++) begin
            for (int a = 0; a < 128; a++) begin
                host_read(pg, a, v);
                chk8(req, v, mdl_rd(pg, a));
            end
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] q[$];
        logic [7:0] v;
        for (int pg = 0; pg < 2; pg++)
            for (int a = 0; a < 128; a++) mdl[pg][a] = 8'h00;
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
        host_page = '0; host_addr = '0; host_we = 1'b0; host_wdata = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state.
        mon_req = "R1";
        exp_miso = 1'b0;
        mon_en = 1;
        host_check_all("R1 reset value");

        // R10: host port writes, including the ignored location 0.
        host_write(0, 5, 8'hA5); host_write(0, 6, 8'h3C);
        host_write(0, 7, 8'h7E); host_write(0, 8, 8'h81);
        host_write(1, 10, 8'h11); host_write(1, 11, 8'h22);
        host_write(1, 12, 8'h33); host_write(1, 13, 8'h44);
        host_write(0, 126, 8'hC3); host_write(0, 127, 8'hD4);
        host_write(1, 126, 8'h9A); host_write(1, 127, 8'hBC);
        host_write(0, 0, 8'h01);
        host_read(0, 0, v);
        chk8("R10 host write to location 0 ignored", v, 8'h00);
        host_check_all("R10 host port");

        // R2 / R5: read burst on page 0.
        q.delete();
        run_frame(5, 1, q, 4);
        chk8("R2 first byte at start address", rdq[0], 8'hA5);

        // R4: write burst.
        q = '{8'hDE, 8'hAD, 8'hBE};
        run_frame(20, 0, q, 3);
        host_check_all("R4 write burst");

        // R6 / R7: switch to page 1.
        q = '{8'h01};
        run_frame(0, 0, q, 1);
        q.delete();
        run_frame(0, 1, q, 1);
        chk8("R6 page readback", rdq[0], 8'h01);
        run_frame(10, 1, q, 4);
        chk8("R7 page 1 data", rdq[3], 8'h44);
        q = '{8'h55, 8'h66};
        run_frame(20, 0, q, 2);
        host_check_all("R7 other page untouched");

        // R6: upper bits of the page write are ignored.
        q = '{8'hFE};
        run_frame(0, 0, q, 1);
        q.delete();
        run_frame(0, 1, q, 1);
        chk8("R6 bit0 only (0xFE)", rdq[0], 8'h00);
        q = '{8'h03};
        run_frame(0, 0, q, 1);
        q.delete();
        run_frame(0, 1, q, 1);
        chk8("R6 bit0 only (0x03)", rdq[0], 8'h01);

        // R8: end of page on page 1.
        q = '{8'h01, 8'h02, 8'h03, 8'h04};
        run_frame(126, 0, q, 4);
        host_check_all("R8 writes past end discarded");
        q.delete();
        run_frame(125, 1, q, 5);
        chk8("R8 last location", rdq[2], 8'h02);
        chk8("R8 zero past end", rdq[3], 8'h00);
        chk8("R8 zero past end", rdq[4], 8'h00);

        // R6: burst through location 0 on page 1, then a page change mid-burst.
        q.delete();
        run_frame(0, 1, q, 3);
        chk8("R6 location 0 in burst", rdq[0], 8'h01);
        q = '{8'h00, 8'h77};
        run_frame(0, 0, q, 2);
        host_check_all("R6 page change mid burst");

        // R3: partial byte discarded.
        partial_frame(30, 8'hF0, 5);
        host_check_all("R3 partial byte");

        // R9: a new frame starts with a command byte.
        q = '{8'h12};
        run_frame(40, 0, q, 1);
        q = '{8'h34};
        run_frame(41, 0, q, 1);
        host_check_all("R9 new command per frame");
        q.delete();
        run_frame(40, 1, q, 2);
        chk8("R9 frame restart", rdq[1], 8'h34);

        mon_en = 0;
        wait_clk(4);
        finish_run();
    end

endmodule